// File: doc/BRIEF.md
# I2C Register-Access Master

This block is an I2C bus master for memory-style slaves that have a 7-bit device address and an 8-bit internal register space. A caller hands it one command at a time: either a single-byte register write or a random-access single-byte register read. The block then runs the whole bus transaction by itself. It drives SCL and SDA as open-drain lines. Each line has an output enable: enable high pulls the line low, and enable low releases it to the pull-up. The block reads SDA back through its own input.

A write sends the device address with the write bit, the register address, the data byte and a stop. Once the stop is on the bus, the block stays busy for a fixed hold-off interval, because the slave is committing the byte internally and would ignore any traffic. A read first sets the slave's register pointer with a write header. It then issues a repeated start, re-addresses the slave with the read bit, receives one byte, refuses it with a not-acknowledge and ends with a stop.

The caller may retry a command that was not acknowledged. The caller sees this through an error flag that is valid when the done pulse fires. The command port uses a valid/ready handshake. Ready is high only while the block is idle, so the caller must hold valid and the command fields steady until it sees ready. A command is taken on the first clock where both valid and ready are high. The block has no queue, so back-pressure lasts for the whole transaction, hold-off included.

Top module: `i2c_regmaster`

## Requirements
- R1: `cmd_ready` is high exactly when `busy` is low. A command is accepted on a clock edge with `cmd_valid` and `cmd_ready` both high, and from the next cycle `busy` is high and `cmd_ready` is low until the command completes.
- R2: Every transaction opens with a start condition (SDA falls while SCL is high), followed by the address byte. The address byte is the 7-bit device address in bits 7..1 and the direction in bit 0 (0 = write, 1 = read). All bytes go MSB first.
- R3: Outside start and stop conditions, SDA changes only while SCL is low. Every SCL low phase lasts exactly `SCL_LOW_CYC` clocks and every SCL high phase lasts at least `SCL_HIGH_CYC` clocks.
- R4: After each byte the master sends, it releases SDA for a ninth clock and samples the line; a low level there is an acknowledge.
- R5: A write command puts on the bus: start, address byte with bit 0 = 0, register byte, data byte, stop. With all three bytes acknowledged, `rsp_err` is 0 at completion.
- R6: If any byte the master sends is not acknowledged, the master sends no further byte, issues a stop, and completes with `rsp_err` = 1 and without the write hold-off.
- R7: After a successful write's stop, `busy` stays high (and `cmd_ready` low) for `WRITE_HOLD_CYC` more clocks before completion. Reads and failed commands skip this interval.
- R8: A read command puts on the bus: start, address byte with bit 0 = 0, register byte, repeated start, address byte with bit 1 = 1 in bit 0, then one byte clocked in from the slave.
- R9: On the ninth clock of the received byte the master leaves SDA high (not-acknowledge), then sends a stop. The received byte appears on `rsp_data` at completion.
- R10: `done` is a one-cycle pulse raised in the first cycle in which `busy` is low after a command. `rsp_err` and `rsp_data` hold their values until the next command is accepted.
- R11: During and right after reset both lines are released, `busy` and `done` are low, `cmd_ready` is high, and `rsp_data` and `rsp_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted (idle) |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_dev | input | 7 | Slave device address |
| cmd_reg | input | 8 | Internal register address |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Command in progress, hold-off included |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte returned by the last read |
| rsp_err | output | 1 | Last command ended on a missing acknowledge |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Level sensed on SDA |

## Verification
The master is tested against a behavioural slave with a byte store and an internal write-cycle timer, and the bench decodes every bus event it sees. Writes and reads use register and data values that have the top bit set, bytes of all zeros and all ones, and pointers both inside and outside the written area. Together these separate a reversed bit order, a wrong direction bit and a wrong ack polarity. Commands to an absent device address, one as a write and one as a read, show whether the abort stop comes at once and whether the error flag is set. A write followed at once by a second write and a read-back shows that the hold-off covers the slave's internal cycle, and the measured distance from stop to done tells a write's hold-off apart from a read's immediate finish.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;

  // Bus primitives executed by the phase engine
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } bus_op_t;

  // Transaction sequencer states
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ISSUE = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_HOLD  = 3'd3,
    SQ_FIN   = 3'd4
  } seq_state_t;

  localparam int BYTE_W     = 8;
  localparam int DEV_W      = 7;
  localparam int BYTE_STEPS = 2 * (BYTE_W + 1);

endpackage

// File: rtl/i2c_phase_engine.sv
// Runs one bus primitive as a list of phases; each phase fixes the SCL
// level and the SDA level for SCL_LOW_CYC or SCL_HIGH_CYC clocks.
module i2c_phase_engine
  import i2c_rm_pkg::*;
#(
  parameter int SCL_LOW_CYC  = 250,
  parameter int SCL_HIGH_CYC = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  bus_op_t           op,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              nack_last,
  output logic              ready,
  output logic              done,
  output logic [BYTE_W-1:0] rbyte,
  output logic              acked,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_i
);

  localparam int MAXC = (SCL_LOW_CYC > SCL_HIGH_CYC) ? SCL_LOW_CYC : SCL_HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int SW   = $clog2(BYTE_STEPS + 1);
  localparam logic [CW-1:0] LOW_LAST  = CW'(SCL_LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(SCL_HIGH_CYC - 1);
  localparam logic [SW-1:0] DATA_END  = SW'(2 * BYTE_W);
  localparam logic [SW-1:0] BYTE_LAST = SW'(BYTE_STEPS - 1);

  logic              active;
  bus_op_t           op_q;
  logic [SW-1:0]     step;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic              nack_q;
  logic              ack_q;
  logic              scl_q;
  logic              sda_q;
  logic              done_q;

  logic              ph_hi;
  logic              ph_sda;
  logic [SW-1:0]     last_step;
  logic              last_cyc;
  logic              is_byte;
  logic              in_data;

  assign in_data = (step < DATA_END);

  always_comb begin
    ph_hi     = 1'b1;
    ph_sda    = 1'b1;
    last_step = '0;
    is_byte   = 1'b0;
    case (op_q)
      OP_START: begin
        last_step = SW'(1);
        ph_sda    = (step == '0);
      end
      OP_RSTART: begin
        last_step = SW'(2);
        ph_hi     = (step != '0);
        ph_sda    = (step != SW'(2));
      end
      OP_STOP: begin
        last_step = SW'(2);
        ph_hi     = (step != '0);
        ph_sda    = (step == SW'(2));
      end
      OP_WRITE: begin
        last_step = BYTE_LAST;
        is_byte   = 1'b1;
        ph_hi     = step[0];
        ph_sda    = in_data ? sh[BYTE_W-1] : 1'b1;
      end
      OP_READ: begin
        last_step = BYTE_LAST;
        is_byte   = 1'b1;
        ph_hi     = step[0];
        ph_sda    = in_data ? 1'b1 : nack_q;
      end
      default: begin
        last_step = '0;
      end
    endcase
    last_cyc = ph_hi ? (cnt == HIGH_LAST) : (cnt == LOW_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      op_q   <= OP_START;
      step   <= '0;
      cnt    <= '0;
      sh     <= '0;
      nack_q <= 1'b1;
      ack_q  <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          op_q   <= op;
          step   <= '0;
          cnt    <= '0;
          sh     <= wbyte;
          nack_q <= nack_last;
        end
      end else begin
        scl_q <= ph_hi;
        // in a low phase SDA keeps its old level for the first clock
        if (ph_hi || (cnt != '0)) sda_q <= ph_sda;
        if (last_cyc) begin
          cnt <= '0;
          if (is_byte && ph_hi) begin
            if (in_data) sh <= {sh[BYTE_W-2:0], sda_i};
            else         ack_q <= ~sda_i;
          end
          if (step == last_step) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign ready  = ~active;
  assign done   = done_q;
  assign rbyte  = sh;
  assign acked  = ack_q;
  assign scl_oe = ~scl_q;
  assign sda_oe = ~sda_q;

  // R3: while a byte is clocked, SDA holds still through SCL high
  p_sda_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && is_byte && scl_q && $past(scl_q)) |-> $stable(sda_q));

  // R4: the master lets go of SDA for the acknowledge clock of a sent byte
  p_ack_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op_q == OP_WRITE && step == BYTE_LAST) |-> sda_q);

endmodule

// File: rtl/i2c_holdoff_timer.sv
// Counts the slave's internal write interval after a write's stop.
module i2c_holdoff_timer #(
  parameter int WRITE_HOLD_CYC = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);

  localparam int HW = $clog2(WRITE_HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(WRITE_HOLD_CYC - 1);

  logic [HW-1:0] cnt;
  logic          running;
  logic          exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == HOLD_LAST) begin
          running <= 1'b0;
          exp_q   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign expired = exp_q;

  // R7: expiry only ever follows a running interval
  p_expire_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> ($past(running) && !running));

endmodule

// File: rtl/i2c_xfer_seq.sv
// Walks the fixed script of bus primitives for a write or a random read.
module i2c_xfer_seq
  import i2c_rm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_read,
  input  logic [DEV_W-1:0]  cmd_dev,
  input  logic [BYTE_W-1:0] cmd_reg,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              e_go,
  output bus_op_t           e_op,
  output logic [BYTE_W-1:0] e_byte,
  output logic              e_nack,
  input  logic              e_done,
  input  logic              e_acked,
  input  logic [BYTE_W-1:0] e_rbyte,
  output logic              hold_start,
  input  logic              hold_expired
);

  seq_state_t        state;
  logic [2:0]        idx;
  logic              rd_q;
  logic              abort_q;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] reg_q;
  logic [BYTE_W-1:0] dat_q;
  logic [BYTE_W-1:0] rdata_q;
  logic              err_q;
  logic              done_q;
  logic [2:0]        stop_idx;

  assign stop_idx = rd_q ? 3'd6 : 3'd4;

  // script: write = S, A+W, REG, DATA, P ; read = S, A+W, REG, Sr, A+R, RD, P
  always_comb begin
    e_op   = OP_STOP;
    e_byte = '0;
    case (idx)
      3'd0: e_op = OP_START;
      3'd1: begin e_op = OP_WRITE; e_byte = {dev_q, 1'b0}; end
      3'd2: begin e_op = OP_WRITE; e_byte = reg_q; end
      3'd3: begin
        if (rd_q) e_op = OP_RSTART;
        else begin e_op = OP_WRITE; e_byte = dat_q; end
      end
      3'd4: begin
        if (rd_q) begin e_op = OP_WRITE; e_byte = {dev_q, 1'b1}; end
        else e_op = OP_STOP;
      end
      3'd5: e_op = OP_READ;
      default: e_op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      idx     <= '0;
      rd_q    <= 1'b0;
      abort_q <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      dat_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (cmd_valid) begin
            rd_q    <= cmd_read;
            dev_q   <= cmd_dev;
            reg_q   <= cmd_reg;
            dat_q   <= cmd_wdata;
            idx     <= '0;
            abort_q <= 1'b0;
            err_q   <= 1'b0;
            state   <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: state <= SQ_WAIT;
        SQ_WAIT: begin
          if (e_done) begin
            if (e_op == OP_STOP) begin
              state <= (!rd_q && !abort_q) ? SQ_HOLD : SQ_FIN;
            end else if (e_op == OP_WRITE && !e_acked) begin
              err_q   <= 1'b1;
              abort_q <= 1'b1;
              idx     <= stop_idx;
              state   <= SQ_ISSUE;
            end else begin
              if (e_op == OP_READ) rdata_q <= e_rbyte;
              idx   <= idx + 1'b1;
              state <= SQ_ISSUE;
            end
          end
        end
        SQ_HOLD: if (hold_expired) state <= SQ_FIN;
        SQ_FIN: begin
          done_q <= 1'b1;
          state  <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state == SQ_IDLE);
  assign busy       = (state != SQ_IDLE);
  assign done       = done_q;
  assign rsp_data   = rdata_q;
  assign rsp_err    = err_q;
  assign e_go       = (state == SQ_ISSUE);
  assign e_nack     = 1'b1;
  assign hold_start = (state == SQ_WAIT) && e_done && (e_op == OP_STOP) && !rd_q && !abort_q;

  // R1: an accepted command makes the block busy and closes the port
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

  // R10: done marks the first idle cycle after a command
  p_done_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10: done lasts one clock
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a refused byte leads straight to a stop with the error set
  p_nack_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_WAIT && e_done && e_op == OP_WRITE && !e_acked)
      |=> (state == SQ_ISSUE && e_op == OP_STOP && rsp_err));

endmodule

// File: rtl/i2c_regmaster.sv
module i2c_regmaster
  import i2c_rm_pkg::*;
#(
  parameter int SCL_LOW_CYC    = 250,
  parameter int SCL_HIGH_CYC   = 250,
  parameter int WRITE_HOLD_CYC = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_read,
  input  logic [6:0] cmd_dev,
  input  logic [7:0] cmd_reg,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rsp_data,
  output logic       rsp_err,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_i
);

  logic              e_go;
  bus_op_t           e_op;
  logic [BYTE_W-1:0] e_byte;
  logic              e_nack;
  logic              e_ready;
  logic              e_done;
  logic [BYTE_W-1:0] e_rbyte;
  logic              e_acked;
  logic              hold_start;
  logic              hold_expired;

  i2c_xfer_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_read     (cmd_read),
    .cmd_dev      (cmd_dev),
    .cmd_reg      (cmd_reg),
    .cmd_wdata    (cmd_wdata),
    .busy         (busy),
    .done         (done),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err),
    .e_go         (e_go),
    .e_op         (e_op),
    .e_byte       (e_byte),
    .e_nack       (e_nack),
    .e_done       (e_done),
    .e_acked      (e_acked),
    .e_rbyte      (e_rbyte),
    .hold_start   (hold_start),
    .hold_expired (hold_expired)
  );

  i2c_phase_engine #(
    .SCL_LOW_CYC  (SCL_LOW_CYC),
    .SCL_HIGH_CYC (SCL_HIGH_CYC)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (e_go),
    .op        (e_op),
    .wbyte     (e_byte),
    .nack_last (e_nack),
    .ready     (e_ready),
    .done      (e_done),
    .rbyte     (e_rbyte),
    .acked     (e_acked),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .sda_i     (sda_i)
  );

  i2c_holdoff_timer #(
    .WRITE_HOLD_CYC (WRITE_HOLD_CYC)
  ) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (hold_start),
    .expired (hold_expired)
  );

  // R1: the sequencer only launches a primitive on an idle engine
  p_engine_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    e_go |-> e_ready);

  // R11: both lines are released whenever no command is running
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/i2c_regmaster_test.sv
module i2c_regmaster_test;

  localparam int LOWC  = 6;
  localparam int HIGHC = 5;
  localparam int HOLDC = 3000;
  localparam int WCYC  = 2500;
  localparam logic [6:0] SLV = 7'h50;
  localparam int EV_S = 1000;
  localparam int EV_P = 1001;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic       cmd_ready;
  logic       cmd_read;
  logic [6:0] cmd_dev;
  logic [7:0] cmd_reg;
  logic [7:0] cmd_wdata;
  logic       busy;
  logic       done;
  logic [7:0] rsp_data;
  logic       rsp_err;
  logic       scl_oe;
  logic       sda_oe;
  logic       sda_i;
  logic       slv_drv;

  always #5 clk = ~clk;

  wire scl_l = ~scl_oe;
  wire sda_l = ~(sda_oe | slv_drv);
  assign sda_i = sda_l;

  i2c_regmaster #(
    .SCL_LOW_CYC    (LOWC),
    .SCL_HIGH_CYC   (HIGHC),
    .WRITE_HOLD_CYC (HOLDC)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_read (cmd_read),
    .cmd_dev (cmd_dev), .cmd_reg (cmd_reg), .cmd_wdata (cmd_wdata),
    .busy (busy), .done (done), .rsp_data (rsp_data), .rsp_err (rsp_err),
    .scl_oe (scl_oe), .sda_oe (sda_oe), .sda_i (sda_i)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int stop_cyc = 0;
  int evlog[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural slave: byte store + write-cycle timer
  logic [7:0] mem [256];
  int         s_bit, s_idx, s_wc;
  logic [7:0] s_sh, s_ptr, s_tx;
  logic       s_ign, s_txm, s_rw, s_pend, s_ack;
  logic       s_pscl, s_psda;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
      slv_drv = 1'b0; s_bit = 0; s_idx = 0; s_wc = 0;
      s_sh = '0; s_ptr = '0; s_tx = '0;
      s_ign = 1'b1; s_txm = 1'b0; s_rw = 1'b0; s_pend = 1'b0; s_ack = 1'b0;
      s_pscl = 1'b1; s_psda = 1'b1;
    end else begin
      if (s_wc > 0) s_wc--;
      if (s_pscl && scl_l && s_psda && !sda_l) begin
        s_bit = 0; s_idx = 0; s_ign = 1'b0; s_txm = 1'b0; slv_drv = 1'b0;
      end else if (s_pscl && scl_l && !s_psda && sda_l) begin
        if (s_pend) s_wc = WCYC;
        s_pend = 1'b0; s_ign = 1'b1; slv_drv = 1'b0;
      end else if (!s_pscl && scl_l && !s_ign) begin
        if (s_bit < 8) begin
          if (!s_txm) s_sh = {s_sh[6:0], sda_l};
          s_bit++;
        end else if (s_bit == 8) begin
          s_bit = 9;
        end
      end else if (s_pscl && !scl_l && !s_ign) begin
        if (s_bit == 8 && !s_txm) begin
          s_ack = 1'b0;
          case (s_idx)
            0: if (s_sh[7:1] == SLV && s_wc == 0) begin s_ack = 1'b1; s_rw = s_sh[0]; end
            1: begin s_ptr = s_sh; s_ack = 1'b1; end
            2: begin mem[s_ptr] = s_sh; s_ptr = s_ptr + 8'd1; s_pend = 1'b1; s_ack = 1'b1; end
            default: s_ack = 1'b0;
          endcase
          if (s_ack) begin slv_drv = 1'b1; s_idx++; end
          else begin slv_drv = 1'b0; s_ign = 1'b1; end
        end else if (s_bit == 9) begin
          slv_drv = 1'b0; s_bit = 0;
          if (s_txm) s_ign = 1'b1;
          else if (s_rw && s_idx == 1) begin
            s_txm = 1'b1; s_tx = mem[s_ptr]; slv_drv = ~s_tx[7];
          end
        end else if (s_txm && s_bit >= 1 && s_bit <= 7) begin
          slv_drv = ~s_tx[7 - s_bit];
        end else if (s_txm && s_bit == 8) begin
          slv_drv = 1'b0;
        end
      end
      s_pscl = scl_l; s_psda = sda_l;
    end
  end

  // ---------------- bus monitor: events, bytes, SCL low width (R3)
  int         m_bit, m_low;
  logic [7:0] m_sh;
  logic       m_pscl, m_psda, m_on;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_bit = 0; m_low = 0; m_sh = '0; m_pscl = 1'b1; m_psda = 1'b1; m_on = 1'b0;
    end else begin
      if (m_pscl && scl_l && m_psda && !sda_l) begin
        evlog.push_back(EV_S); m_bit = 0; m_on = 1'b1;
      end else if (m_pscl && scl_l && !m_psda && sda_l) begin
        evlog.push_back(EV_P); m_bit = 0; stop_cyc = cyc;
      end else if (!m_pscl && scl_l) begin
        if (m_on) chk(m_low == LOWC, "R3 scl low width", m_low, LOWC);
        if (m_bit < 8) begin m_sh = {m_sh[6:0], sda_l}; m_bit++; end
        else begin evlog.push_back(int'(m_sh) * 2 + int'(sda_l)); m_bit = 0; end
      end else if (m_pscl && !scl_l) begin
        m_low = 0;
      end
      if (!scl_l) m_low++;
      m_pscl = scl_l; m_psda = sda_l;
    end
  end

  // ---------------- per-clock handshake reference (R1, R10)
  logic pv_busy, pv_done;
  always @(negedge clk) begin
    if (!rst_n) begin
      pv_busy = 1'b0; pv_done = 1'b0;
    end else begin
      chk(cmd_ready == ~busy, "R1 ready equals not busy", int'(cmd_ready), int'(~busy));
      if (done) chk(!busy && pv_busy, "R10 done at busy fall", int'(pv_busy), 1);
      if (pv_done) chk(!done, "R10 done width", int'(done), 0);
      pv_busy = busy; pv_done = done;
    end
  end

  // ---------------- command driver
  task automatic run_cmd(input bit rd, input logic [6:0] dv, input logic [7:0] rg,
                         input logic [7:0] wd, output int s2d);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    evlog.delete();
    cmd_valid = 1'b1; cmd_read = rd; cmd_dev = dv; cmd_reg = rg; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy && !cmd_ready, "R1 busy after accept", int'(busy), 1);
    while (!done) @(negedge clk);
    s2d = cyc - stop_cyc;
  endtask

  task automatic chk_log(input int exp[$], input string req);
    chk(evlog.size() == exp.size(), req, evlog.size(), exp.size());
    for (int i = 0; i < exp.size() && i < evlog.size(); i++)
      chk(evlog[i] == exp[i], req, evlog[i], exp[i]);
  endtask

  // ---------------- watchdog
  bit finished = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence
  int s2d;
  int ex[$];
  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0;
    cmd_dev = '0; cmd_reg = '0; cmd_wdata = '0;
    repeat (4) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R11 lines released in reset", int'({scl_oe, sda_oe}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && cmd_ready && !done, "R11 idle after reset", int'({busy, cmd_ready, done}), 2);
    chk(rsp_data == 8'h00 && !rsp_err, "R11 response cleared", int'({rsp_err, rsp_data}), 0);
    chk(!scl_oe && !sda_oe, "R11 lines released after reset", int'({scl_oe, sda_oe}), 0);

    // R5 R2 R4 R7: write with MSB-set data
    run_cmd(1'b0, SLV, 8'h12, 8'hC3, s2d);
    ex = '{EV_S, 8'hA0 * 2, 8'h12 * 2, 8'hC3 * 2, EV_P};
    chk_log(ex, "R5 write bus sequence");
    chk(!rsp_err, "R5 write no error", int'(rsp_err), 0);
    chk(s2d >= HOLDC && s2d <= HOLDC + HIGHC + 10, "R7 hold-off after write", s2d, HOLDC);

    // R8 R9: random read of the written byte
    run_cmd(1'b1, SLV, 8'h12, 8'h00, s2d);
    ex = '{EV_S, 8'hA0 * 2, 8'h12 * 2, EV_S, 8'hA1 * 2, 8'hC3 * 2 + 1, EV_P};
    chk_log(ex, "R8 read bus sequence");
    chk(rsp_data == 8'hC3, "R9 read data", int'(rsp_data), 8'hC3);
    chk(!rsp_err, "R9 read no error", int'(rsp_err), 0);
    chk(s2d < 40, "R7 read skips hold-off", s2d, 0);
    chk(rsp_data == 8'hC3, "R10 data held after done", int'(rsp_data), 8'hC3);

    // R6: write to an absent device
    run_cmd(1'b0, 7'h23, 8'h05, 8'h77, s2d);
    ex = '{EV_S, 8'h46 * 2 + 1, EV_P};
    chk_log(ex, "R6 write abort sequence");
    chk(rsp_err, "R6 error flag on nack", int'(rsp_err), 1);
    chk(s2d < 40, "R6 no hold-off after abort", s2d, 0);

    // R8 R9: untouched location returns preset content
    run_cmd(1'b1, SLV, 8'h40, 8'h00, s2d);
    ex = '{EV_S, 8'hA0 * 2, 8'h40 * 2, EV_S, 8'hA1 * 2, 8'h1A * 2 + 1, EV_P};
    chk_log(ex, "R8 read preset sequence");
    chk(rsp_data == 8'h1A, "R9 read preset data", int'(rsp_data), 8'h1A);
    chk(!rsp_err, "R10 error cleared by new command", int'(rsp_err), 0);

    // R2 R5: all-ones register, all-zero data, then read back
    run_cmd(1'b0, SLV, 8'hFF, 8'h00, s2d);
    ex = '{EV_S, 8'hA0 * 2, 8'hFF * 2, 8'h00, EV_P};
    chk_log(ex, "R2 write zero data sequence");
    run_cmd(1'b1, SLV, 8'hFF, 8'h00, s2d);
    chk(rsp_data == 8'h00, "R9 read zero data", int'(rsp_data), 0);

    // R6: read from an absent device
    run_cmd(1'b1, 7'h51, 8'h10, 8'h00, s2d);
    ex = '{EV_S, 8'hA2 * 2 + 1, EV_P};
    chk_log(ex, "R6 read abort sequence");
    chk(rsp_err, "R6 read error flag", int'(rsp_err), 1);

    // R7: back-to-back writes are both acknowledged thanks to the hold-off
    run_cmd(1'b0, SLV, 8'h01, 8'h81, s2d);
    chk(!rsp_err, "R7 first write", int'(rsp_err), 0);
    run_cmd(1'b0, SLV, 8'h02, 8'h7E, s2d);
    chk(!rsp_err, "R7 second write after hold-off", int'(rsp_err), 0);
    run_cmd(1'b1, SLV, 8'h01, 8'h00, s2d);
    chk(rsp_data == 8'h81, "R9 read back first write", int'(rsp_data), 8'h81);
    run_cmd(1'b1, SLV, 8'h02, 8'h00, s2d);
    chk(rsp_data == 8'h7E, "R9 read back second write", int'(rsp_data), 8'h7E);

    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe, "R11 lines released when idle", int'({scl_oe, sda_oe}), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule